// File: doc/BRIEF.md
# Two-Stage Carry-Split Pipelined Adder

This block adds two 32-bit operands and a carry-in. It splits the ripple carry chain at its midpoint with one register rank, which halves the longest combinational path. The chain is made of four 8-bit slices. The lower two slices resolve in the first cycle and store their carry. The upper two slices resolve in the second cycle from that stored carry. The upper operand bits and the lower partial sum go through skew registers, so each result leaves as one coherent 33-bit word.

A new operand pair may be presented on every clock edge. A valid flag travels with the data, and each result appears two cycles after its operands, together with its carry-out. There is no stall and no flush. The only control input is a synchronous reset, which clears the valid flags.

Top module: `split_adder`

## Requirements
- R1: When `out_valid` is high, `{out_cout, out_sum}` equals `in_a + in_b + in_cin` of the operands presented two rising edges earlier, computed to 33 bits.
- R2: `out_valid` equals `in_valid` as it was two rising edges earlier.
- R3: A new operand pair is accepted on every edge. When results come back-to-back, each one matches its own operand pair, with no mixing of halves from neighbouring pairs.
- R4: A carry produced in bits 15:0 reaches bits 31:16 of the same result. For example, 0x0000FFFF + 0x00000001 gives 0x00010000.
- R5: A carry out of bit 31 appears on `out_cout` in the same cycle as its sum. For example, 0xFFFFFFFF + 0 + carry-in 1 gives a sum of 0 and `out_cout` = 1.
- R6: If `rst` is high at a rising edge, both valid stages clear, so `out_valid` is low after that edge and after the edge that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers capture on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| in_valid | input | 1 | Marks the operands on this edge as a real request |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | Result on the outputs is valid |
| out_sum | output | 32 | Sum bits 31:0 |
| out_cout | output | 1 | Carry out of bit 31 |

## Verification
Every result and its valid flag are due exactly two rising edges after the operands that produced them. The bench drives inputs and samples outputs on the falling edge. A behavioural model holds two slots per edge: one slot for the request captured at the coming edge and one for the request due on the outputs now. After each edge the model compares the outputs with the older slot, and a reset edge empties both slots. Directed cases aim at the midpoint carry and the full-width carry. Long random back-to-back streams check that results from neighbouring pairs keep their halves apart.

// File: rtl/split_add_pkg.sv
package split_add_pkg;
    localparam int unsigned DEF_WIDTH   = 32;
    localparam int unsigned DEF_SLICE_W = 8;
endpackage

// File: rtl/add_slice.sv
module add_slice #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        s    = full[W-1:0];
        co   = full[W];
    end
endmodule

// File: rtl/add_chain.sv
module add_chain #(
    parameter int unsigned SLICE_W = 8,
    parameter int unsigned SLICES  = 2,
    localparam int unsigned W      = SLICE_W * SLICES
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [SLICES:0] carry;

    assign carry[0] = ci;

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        add_slice #(.W(SLICE_W)) slice_i (
            .a  (a[g*SLICE_W +: SLICE_W]),
            .b  (b[g*SLICE_W +: SLICE_W]),
            .ci (carry[g]),
            .s  (s[g*SLICE_W +: SLICE_W]),
            .co (carry[g+1])
        );
    end

    assign co = carry[SLICES];
endmodule

// File: rtl/split_adder.sv
module split_adder
    import split_add_pkg::*;
#(
    parameter int unsigned WIDTH   = DEF_WIDTH,
    parameter int unsigned SLICE_W = DEF_SLICE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             in_cin,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_cout
);
    localparam int unsigned LO_W      = WIDTH / 2;
    localparam int unsigned HI_W      = WIDTH - LO_W;
    localparam int unsigned LO_SLICES = LO_W / SLICE_W;
    localparam int unsigned HI_SLICES = HI_W / SLICE_W;

    typedef struct packed {
        logic            v1;
        logic [LO_W-1:0] lo_sum;
        logic            mid_carry;
        logic [HI_W-1:0] a_hi;
        logic [HI_W-1:0] b_hi;
        logic             v2;
        logic [WIDTH-1:0] sum;
        logic             cout;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [LO_W-1:0] lo_s;
    logic            lo_co;
    logic [HI_W-1:0] hi_s;
    logic            hi_co;

    // Stage 1: lower half of the carry chain, fed straight from the inputs
    add_chain #(.SLICE_W(SLICE_W), .SLICES(LO_SLICES)) lo_chain_i (
        .a  (in_a[LO_W-1:0]),
        .b  (in_b[LO_W-1:0]),
        .ci (in_cin),
        .s  (lo_s),
        .co (lo_co)
    );

    // Stage 2: upper half, fed from skewed operands and the stored mid carry
    add_chain #(.SLICE_W(SLICE_W), .SLICES(HI_SLICES)) hi_chain_i (
        .a  (st_q.a_hi),
        .b  (st_q.b_hi),
        .ci (st_q.mid_carry),
        .s  (hi_s),
        .co (hi_co)
    );

    always_comb begin
        st_d           = st_q;
        st_d.v1        = in_valid;
        st_d.lo_sum    = lo_s;
        st_d.mid_carry = lo_co;
        st_d.a_hi      = in_a[WIDTH-1:LO_W];
        st_d.b_hi      = in_b[WIDTH-1:LO_W];
        st_d.v2        = st_q.v1;
        st_d.sum       = {hi_s, st_q.lo_sum};
        st_d.cout      = hi_co;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (rst) begin
            st_q.v1 <= 1'b0;
            st_q.v2 <= 1'b0;
        end
    end

    assign out_valid = st_q.v2;
    assign out_sum   = st_q.sum;
    assign out_cout  = st_q.cout;

    // Assertion support: counts clean edges since reset, saturating at two
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    a_r1_sum: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2 && out_valid) |->
        ({out_cout, out_sum} == ({1'b0, $past(in_a, 2)} + {1'b0, $past(in_b, 2)}
                                 + {{WIDTH{1'b0}}, $past(in_cin, 2)})));

    a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r5_top_carry: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2 && out_valid && $past(in_cin, 2)
         && ($past(in_a, 2) == {WIDTH{1'b1}}) && ($past(in_b, 2) == '0))
        |-> (out_cout && out_sum == '0));

    a_r6_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);
endmodule

// File: tb/split_adder_tb.sv
module split_adder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        in_cin = 1'b0;
    logic        out_valid;
    logic [31:0] out_sum;
    logic        out_cout;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Model slots: s1 = captured at next edge, s2 = due on outputs now
    logic        m1_v = 1'b0, m2_v = 1'b0;
    logic [32:0] m1_r = '0,   m2_r = '0;
    string       m1_tag = "R1", m2_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    split_adder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_cin(in_cin),
        .out_valid(out_valid), .out_sum(out_sum), .out_cout(out_cout)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic compare(input string vtag);
        checks++;
        if (out_valid !== m2_v) begin
            fails++;
            $display("FAIL %s valid: actual %b expected %b", vtag, out_valid, m2_v);
        end
        if (m2_v) begin
            checks++;
            if ({out_cout, out_sum} !== m2_r) begin
                fails++;
                $display("FAIL %s result: actual %h expected %h", m2_tag, {out_cout, out_sum}, m2_r);
            end
        end
    endtask

    // One cycle: check outputs, drive the next request, advance the model
    task automatic step(input logic r, input logic v, input logic [31:0] a,
                        input logic [31:0] b, input logic c, input string tag,
                        input string vtag);
        @(negedge clk);
        compare(vtag);
        rst = r; in_valid = v; in_a = a; in_b = b; in_cin = c;
        if (r) begin
            m2_v = 1'b0; m1_v = 1'b0;
        end else begin
            m2_v = m1_v; m2_r = m1_r; m2_tag = m1_tag;
            m1_v = v;
            m1_r = {1'b0, a} + {1'b0, b} + {32'd0, c};
            m1_tag = tag;
        end
    endtask

    initial begin
        // Reset state (R6)
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 32'h1, 32'h1, 1'b0, "R6", "R6");
        // Midpoint carry (R4) and full carry-out (R5)
        step(1'b0, 1'b1, 32'h0000FFFF, 32'h00000001, 1'b0, "R4", "R6");
        step(1'b0, 1'b1, 32'h0000FFFF, 32'h00000000, 1'b1, "R4", "R6");
        step(1'b0, 1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b1, "R5", "R2");
        step(1'b0, 1'b1, 32'h80000000, 32'h80000000, 1'b0, "R5", "R2");
        step(1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R5", "R2");
        step(1'b0, 1'b1, 32'h00000000, 32'h00000000, 1'b0, "R1", "R2");
        // Valid gaps (R2)
        for (int i = 0; i < 40; i++)
            step(1'b0, (i % 3) != 0, $urandom, $urandom, 1'($urandom), "R1", "R2");
        // Back-to-back random stream with distinct upper halves (R3)
        for (int i = 0; i < 2000; i++)
            step(1'b0, 1'b1, $urandom, $urandom, 1'($urandom), "R3", "R2");
        // Reset in mid-stream drops in-flight results (R6)
        step(1'b1, 1'b1, 32'h12345678, 32'h1, 1'b0, "R6", "R2");
        step(1'b0, 1'b1, 32'h0000FFFF, 32'h0000FFFF, 1'b1, "R4", "R6");
        step(1'b0, 1'b1, 32'hFFFF0000, 32'h00010000, 1'b0, "R5", "R6");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 32'h0, 32'h0, 1'b0, "R1", "R2");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule